// File: doc/BRIEF.md
# Challenge-Response Debug Access Gate

This block sits behind a standard IEEE 1149.1 test access port and decides whether the on-chip debug port may be used. It contains the TAP state machine, a 4-bit instruction register, a one-bit bypass register, a data register that presents a device-unique challenge to the host, and a data register that receives the host's answer. When the security mode asks for authentication, debug access is granted only after the host has read the challenge and then shifted in a 128-bit answer that equals a reference value held in fuses.

The security configuration arrives as static inputs. A two-bit mode field selects always-open, authentication-required or never-open operation. A kill input shuts everything off. A software enable opens debug in any mode unless a companion override input defeats it. A separate select input steers the port between debug operation and test-only operation. Once granted, access persists across TAP resets and is withdrawn only by the system reset.

Top module: `jgate_top`

## Requirements
- R1: The instruction register is 4 bits wide and loads 4'b0001 in Capture-IR. TRST or the Test-Logic-Reset state selects 4'hF (bypass). Any code other than 4'h9 or 4'h1 selects a one-bit bypass register that captures 0, so TDO repeats TDI one shift later.
- R2: With instruction 4'h9, Capture-DR loads the 64-bit challenge. Shift-DR then presents it on TDO least significant bit first, so the low 32-bit word leaves before the high word.
- R3: With instruction 4'h1, Shift-DR moves TDI into a 128-bit answer register. The first bit shifted lands in bit 0, so the lowest 32-bit word goes in first. The answer is compared with the reference only in the Update-DR state of that instruction.
- R4: With mode 2'b01, dbgEnable rises after an Update-DR whose answer equals all 128 reference bits. An answer that differs in any bit leaves the gate locked.
- R5: With mode 2'b00, dbgEnable is high without any authentication.
- R6: With mode 2'b11, or the reserved value 2'b10, dbgEnable stays low even after a matching answer.
- R7: swDbgEn high opens debug whatever the mode, unless swOverride is high. When swOverride is high, swDbgEn has no effect.
- R8: jtagOff high forces dbgEnable, testEnable and tdo low. A matching answer sent while jtagOff is high grants nothing, which is still visible after jtagOff is released.
- R9: modeSel high selects test-only operation: testEnable high and dbgEnable low. modeSel low gives testEnable low.
- R10: sysRstN low clears a granted unlock. trstN and the Test-Logic-Reset state do not clear it.
- R11: tdo is low whenever the TAP is in neither Shift-IR nor Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state advances on its rising edge |
| trstN | input | 1 | Asynchronous active-low TAP reset |
| sysRstN | input | 1 | Asynchronous active-low device reset; relocks the gate |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out |
| challenge | input | 64 | Device-unique challenge value |
| refResp | input | 128 | Fused reference answer |
| secMode | input | 2 | Security mode: 00 open, 01 authenticate, 11 closed |
| jtagOff | input | 1 | Kill input; blocks every access path |
| swDbgEn | input | 1 | Software debug enable |
| swOverride | input | 1 | Defeats swDbgEn when high |
| modeSel | input | 1 | 0 debug operation, 1 test-only operation |
| dbgEnable | output | 1 | Debug port access granted |
| testEnable | output | 1 | Test-only port enabled |

## Verification
The bench builds the gate with its default parameters: a 64-bit challenge, a 128-bit answer, a 4-bit instruction register, and codes 4'h9 and 4'h1. At these widths a whole challenge fits in one scan and a full answer in another. The bench can therefore cover the word order on both paths, an answer that differs in a single high bit, and the bypass register's one-shift delay. It also walks every mode value, and the kill and software-enable inputs, against the same matching answer.

// File: rtl/jgate_pkg.sv
package jgate_pkg;

  typedef enum logic [3:0] {
    TAP_TLR, TAP_RTI,
    TAP_SEL_DR, TAP_CAP_DR, TAP_SH_DR, TAP_EX1_DR, TAP_PAU_DR, TAP_EX2_DR, TAP_UPD_DR,
    TAP_SEL_IR, TAP_CAP_IR, TAP_SH_IR, TAP_EX1_IR, TAP_PAU_IR, TAP_EX2_IR, TAP_UPD_IR
  } tapState_t;

  // strobes from the TAP control to the data registers
  typedef struct packed {
    logic capDr;
    logic shDr;
    logic updDr;
    logic selChal;
    logic selResp;
  } drStrobe_t;

endpackage

// File: rtl/jgate_ctrl.sv
module jgate_ctrl
  import jgate_pkg::*;
#(
  parameter int IR_W    = 4,
  parameter int IR_CHAL = 9,
  parameter int IR_RESP = 1
) (
  input  logic      tck,
  input  logic      trstN,
  input  logic      tms,
  input  logic      tdi,
  output drStrobe_t strb,
  output logic      shIr,
  output logic      irTdo
);

  localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);
  localparam logic [IR_W-1:0] IR_BYPASS  = '1;

  tapState_t state, nextState;
  logic [IR_W-1:0] irSh, irReg;

  always_comb begin
    case (state)
      TAP_TLR:    nextState = tms ? TAP_TLR    : TAP_RTI;
      TAP_RTI:    nextState = tms ? TAP_SEL_DR : TAP_RTI;
      TAP_SEL_DR: nextState = tms ? TAP_SEL_IR : TAP_CAP_DR;
      TAP_CAP_DR: nextState = tms ? TAP_EX1_DR : TAP_SH_DR;
      TAP_SH_DR:  nextState = tms ? TAP_EX1_DR : TAP_SH_DR;
      TAP_EX1_DR: nextState = tms ? TAP_UPD_DR : TAP_PAU_DR;
      TAP_PAU_DR: nextState = tms ? TAP_EX2_DR : TAP_PAU_DR;
      TAP_EX2_DR: nextState = tms ? TAP_UPD_DR : TAP_SH_DR;
      TAP_UPD_DR: nextState = tms ? TAP_SEL_DR : TAP_RTI;
      TAP_SEL_IR: nextState = tms ? TAP_TLR    : TAP_CAP_IR;
      TAP_CAP_IR: nextState = tms ? TAP_EX1_IR : TAP_SH_IR;
      TAP_SH_IR:  nextState = tms ? TAP_EX1_IR : TAP_SH_IR;
      TAP_EX1_IR: nextState = tms ? TAP_UPD_IR : TAP_PAU_IR;
      TAP_PAU_IR: nextState = tms ? TAP_EX2_IR : TAP_PAU_IR;
      TAP_EX2_IR: nextState = tms ? TAP_UPD_IR : TAP_SH_IR;
      TAP_UPD_IR: nextState = tms ? TAP_SEL_DR : TAP_RTI;
      default:    nextState = TAP_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= TAP_TLR;
    else        state <= nextState;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irSh  <= IR_CAPTURE;
      irReg <= IR_BYPASS;
    end else begin
      case (state)
        TAP_TLR:    irReg <= IR_BYPASS;
        TAP_CAP_IR: irSh  <= IR_CAPTURE;
        TAP_SH_IR:  irSh  <= {tdi, irSh[IR_W-1:1]};
        TAP_UPD_IR: irReg <= irSh;
        default:    ;
      endcase
    end
  end

  always_comb begin
    strb.capDr   = (state == TAP_CAP_DR);
    strb.shDr    = (state == TAP_SH_DR);
    strb.updDr   = (state == TAP_UPD_DR);
    strb.selChal = (irReg == IR_W'(IR_CHAL));
    strb.selResp = (irReg == IR_W'(IR_RESP));
  end

  assign shIr  = (state == TAP_SH_IR);
  assign irTdo = irSh[0];

  AST_TLR_SELECTS_BYPASS: assert property (@(posedge tck) disable iff (!trstN)
    (state == TAP_TLR) |=> (irReg == IR_BYPASS)); // R1

  AST_CAPIR_PATTERN: assert property (@(posedge tck) disable iff (!trstN)
    (state == TAP_CAP_IR) |=> (irSh == IR_CAPTURE)); // R1

endmodule

// File: rtl/jgate_dp.sv
module jgate_dp
  import jgate_pkg::*;
#(
  parameter int CHAL_W = 64,
  parameter int RESP_W = 128
) (
  input  logic              tck,
  input  logic              sysRstN,
  input  logic              tdi,
  input  drStrobe_t         strb,
  input  logic [CHAL_W-1:0] challenge,
  input  logic [RESP_W-1:0] refResp,
  input  logic              authAllowed,
  output logic              drTdo,
  output logic              unlocked
);

  logic [CHAL_W-1:0] chalSh;
  logic [RESP_W-1:0] respSh;
  logic              bypassBit;
  logic              respMatch;

  always_ff @(posedge tck) begin
    if (strb.capDr) begin
      bypassBit <= 1'b0;
      if (strb.selChal) chalSh <= challenge;
    end else if (strb.shDr) begin
      if (strb.selChal)      chalSh    <= {tdi, chalSh[CHAL_W-1:1]};
      else if (strb.selResp) respSh    <= {tdi, respSh[RESP_W-1:1]};
      else                   bypassBit <= tdi;
    end
  end

  assign drTdo     = strb.selChal ? chalSh[0] : (strb.selResp ? respSh[0] : bypassBit);
  assign respMatch = (respSh == refResp);

  // grant flop: only the device reset withdraws it
  always_ff @(posedge tck or negedge sysRstN) begin
    if (!sysRstN)
      unlocked <= 1'b0;
    else if (strb.updDr && strb.selResp && authAllowed && respMatch)
      unlocked <= 1'b1;
  end

  AST_GRANT_STICKY: assert property (@(posedge tck) disable iff (!sysRstN)
    unlocked |=> unlocked); // R10

  AST_GRANT_AT_UPDATE: assert property (@(posedge tck) disable iff (!sysRstN)
    $rose(unlocked) |-> $past(strb.updDr && strb.selResp)); // R3

  AST_MISMATCH_LOCKED: assert property (@(posedge tck) disable iff (!sysRstN)
    (strb.updDr && !respMatch && !unlocked) |=> !unlocked); // R4

endmodule

// File: rtl/jgate_top.sv
module jgate_top
  import jgate_pkg::*;
#(
  parameter int CHAL_W  = 64,
  parameter int RESP_W  = 128,
  parameter int IR_W    = 4,
  parameter int IR_CHAL = 9,
  parameter int IR_RESP = 1
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              sysRstN,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  input  logic [CHAL_W-1:0] challenge,
  input  logic [RESP_W-1:0] refResp,
  input  logic [1:0]        secMode,
  input  logic              jtagOff,
  input  logic              swDbgEn,
  input  logic              swOverride,
  input  logic              modeSel,
  output logic              dbgEnable,
  output logic              testEnable
);

  drStrobe_t strb;
  logic shIr, irTdo, drTdo, unlocked;
  logic authAllowed, swOpen, modeOpen;

  jgate_ctrl #(.IR_W(IR_W), .IR_CHAL(IR_CHAL), .IR_RESP(IR_RESP)) ctrl_i (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi),
    .strb(strb), .shIr(shIr), .irTdo(irTdo)
  );

  jgate_dp #(.CHAL_W(CHAL_W), .RESP_W(RESP_W)) dp_i (
    .tck(tck), .sysRstN(sysRstN), .tdi(tdi), .strb(strb),
    .challenge(challenge), .refResp(refResp), .authAllowed(authAllowed),
    .drTdo(drTdo), .unlocked(unlocked)
  );

  assign authAllowed = !jtagOff && (secMode == 2'b01);
  assign swOpen      = swDbgEn && !swOverride;

  always_comb begin
    case (secMode)
      2'b00:   modeOpen = 1'b1;
      2'b01:   modeOpen = unlocked;
      default: modeOpen = 1'b0;
    endcase
  end

  assign dbgEnable  = !jtagOff && !modeSel && (swOpen || modeOpen);
  assign testEnable = !jtagOff && modeSel;
  assign tdo        = jtagOff ? 1'b0 : (shIr ? irTdo : (strb.shDr ? drTdo : 1'b0));

  AST_KILL_BLOCKS_ALL: assert property (@(posedge tck) disable iff (!sysRstN)
    jtagOff |-> (!dbgEnable && !testEnable && !tdo)); // R8

  AST_CLOSED_MODE: assert property (@(posedge tck) disable iff (!sysRstN)
    ((secMode == 2'b11) && !(swDbgEn && !swOverride)) |-> !dbgEnable); // R6

  AST_PORT_EXCLUSIVE: assert property (@(posedge tck) disable iff (!sysRstN)
    !(dbgEnable && testEnable)); // R9

  AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!sysRstN)
    (!shIr && !strb.shDr) |-> !tdo); // R11

endmodule

// File: tb/jgate_tb.sv
module jgate_top_tb_top;

  localparam int CLK_P = 10;
  localparam logic [63:0]  CHAL = 64'hDEAD_BEEF_1357_9BDF;
  localparam logic [127:0] SECRET = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

  logic tck = 1'b0, trstN, sysRstN, tms, tdi, tdo;
  logic [1:0] secMode;
  logic jtagOff, swDbgEn, swOverride, modeSel, dbgEnable, testEnable;
  int checks = 0, errors = 0;

  typedef struct { string req; logic [127:0] val; } item_t;
  item_t expQ[$];

  always #(CLK_P/2) tck = ~tck;

  jgate_top dut_i (
    .tck(tck), .trstN(trstN), .sysRstN(sysRstN), .tms(tms), .tdi(tdi), .tdo(tdo),
    .challenge(CHAL), .refResp(SECRET), .secMode(secMode), .jtagOff(jtagOff),
    .swDbgEn(swDbgEn), .swOverride(swOverride), .modeSel(modeSel),
    .dbgEnable(dbgEnable), .testEnable(testEnable)
  );

  // driver side: expected items into the scoreboard
  task automatic expectVal(input string req, input logic [127:0] val);
    expQ.push_back('{req, val});
  endtask

  // monitor side: pop and compare against what the design produced
  task automatic observe(input logic [127:0] act);
    item_t it;
    it = expQ.pop_front();
    checks++;
    if (act !== it.val) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", it.req, act, it.val);
    end
  endtask

  task automatic step(input logic m, input logic d);
    @(negedge tck); tms = m; tdi = d;
    @(posedge tck);
  endtask

  task automatic shiftBits(input logic [127:0] din, input int n, output logic [127:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge tck);
      dout[i] = tdo;
      tms = (i == n-1);
      tdi = din[i];
      @(posedge tck);
    end
    step(1, 0);   // Exit1 -> Update
    step(0, 0);   // Update -> Run-Test/Idle
  endtask

  task automatic scanIr(input logic [3:0] code, output logic [127:0] dout);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    shiftBits({124'b0, code}, 4, dout);
  endtask

  task automatic scanDr(input logic [127:0] din, input int n, output logic [127:0] dout);
    step(1, 0); step(0, 0); step(0, 0);
    shiftBits(din, n, dout);
  endtask

  task automatic sendAnswer(input logic [127:0] ans);
    logic [127:0] d;
    scanIr(4'h1, d);
    scanDr(ans, 128, d);
  endtask

  task automatic sample(input string req, input logic [127:0] exp, input logic [127:0] act);
    expectVal(req, exp);
    observe(act);
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] d;
    trstN = 0; sysRstN = 0; tms = 1; tdi = 0;
    secMode = 2'b01; jtagOff = 0; swDbgEn = 0; swOverride = 0; modeSel = 0;
    repeat (3) @(posedge tck);
    @(negedge tck); trstN = 1; sysRstN = 1;
    step(0, 0);

    #1;
    sample("R10 locked after reset", 128'd0, {127'd0, dbgEnable});
    sample("R9 testEnable low in debug op", 128'd0, {127'd0, testEnable});
    sample("R11 tdo low in idle", 128'd0, {127'd0, tdo});

    scanIr(4'h9, d);
    sample("R1 IR capture pattern", 128'h1, {124'd0, d[3:0]});
    scanDr(128'd0, 64, d);
    sample("R2 challenge low word first", {64'd0, CHAL}, {64'd0, d[63:0]});

    scanIr(4'hF, d);
    scanDr(128'b101, 3, d);
    sample("R1 bypass one-shift delay", 128'b010, {125'd0, d[2:0]});

    sendAnswer(SECRET ^ (128'd1 << 127));
    #1 sample("R4 mismatch stays locked", 128'd0, {127'd0, dbgEnable});

    sendAnswer(SECRET);
    #1 sample("R3 R4 matching answer unlocks", 128'd1, {127'd0, dbgEnable});

    @(negedge tck); trstN = 0;
    @(negedge tck); trstN = 1;
    step(1, 0); step(1, 0); step(1, 0); step(1, 0); step(1, 0); step(0, 0);
    #1 sample("R10 TRST and TLR keep grant", 128'd1, {127'd0, dbgEnable});

    modeSel = 1; #1;
    sample("R9 test-only enables test", 128'd1, {127'd0, testEnable});
    sample("R9 test-only hides debug", 128'd0, {127'd0, dbgEnable});
    modeSel = 0;

    @(negedge tck); sysRstN = 0;
    @(negedge tck); sysRstN = 1;
    #1 sample("R10 device reset relocks", 128'd0, {127'd0, dbgEnable});

    secMode = 2'b00; #1;
    sample("R5 open mode", 128'd1, {127'd0, dbgEnable});

    secMode = 2'b11;
    sendAnswer(SECRET);
    #1 sample("R6 closed mode ignores answer", 128'd0, {127'd0, dbgEnable});
    secMode = 2'b10; #1;
    sample("R6 reserved mode closed", 128'd0, {127'd0, dbgEnable});

    secMode = 2'b11; swDbgEn = 1; #1;
    sample("R7 software enable opens", 128'd1, {127'd0, dbgEnable});
    swOverride = 1; #1;
    sample("R7 override defeats software enable", 128'd0, {127'd0, dbgEnable});
    swDbgEn = 0; swOverride = 0;

    secMode = 2'b01; jtagOff = 1;
    scanIr(4'h9, d);
    sample("R8 IR scan silent when killed", 128'd0, {124'd0, d[3:0]});
    scanDr(128'd0, 64, d);
    sample("R8 challenge hidden when killed", 128'd0, {64'd0, d[63:0]});
    modeSel = 1; #1;
    sample("R8 test op blocked when killed", 128'd0, {127'd0, testEnable});
    modeSel = 0;
    sendAnswer(SECRET);
    @(negedge tck); jtagOff = 0; #1;
    sample("R8 answer while killed grants nothing", 128'd0, {127'd0, dbgEnable});
    sample("R11 tdo low after scans", 128'd0, {127'd0, tdo});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule